// File: doc/BRIEF.md
# I2C Register Bank with Staged, Event-Timed Commit

This block is an I2C slave that fronts a small bank of control registers for a video pipeline. Bytes written by the bus master go into a staging copy of the bank. They reach the active copy, which drives the parallel output bus, only after two things have happened. First, the master writes any byte to the store subaddress `FFh`. Second, the timing event that owns the register's group arrives. Registers in the sync group are copied on the next vertical-sync pulse. Registers in the output group are copied on the next output-cycle start pulse.

A status byte at subaddress `33h` tells the master how the commit is progressing. It holds one done bit per group and a flag that reports a fresh noise-measurement result. Both write and read transfers use a subaddress pointer that advances after every data byte and wraps from `FFh` to `00h`.

SCL and SDA are oversampled by the system clock through a two-flop synchronizer and a glitch filter. The block drives SDA only through an open-drain enable.

Top module: `i2c_cmt_regbank`

## Requirements
- R1: The slave acknowledges only the 7-bit address `7'h5E` (address byte `8'hBC` for a write, `8'hBD` for a read). Any other address is not acknowledged, and the bytes that follow it up to the next stop have no effect.
- R2: A write transfer stores its data bytes into consecutive staging registers starting at the subaddress. A read transfer (subaddress write, repeated start, read address) returns consecutive staged values. Mapped registers sit at subaddresses `00h` to `NUM_REGS-1`.
- R3: The active register outputs (`act_o`, register k in bits `[8k+7:8k]`) do not change while neither event input is pulsing.
- R4: Writing any byte to subaddress `FFh` clears status bits 0 (sync group done) and 1 (output group done) of subaddress `33h` to 0.
- R5: After a store, the next `vsync_i` pulse copies every sync-group register (`OS_MASK` bit 0) from staging to active and sets status bit 0.
- R6: After a store, the next `ostart_i` pulse copies every output-group register (`OS_MASK` bit 1) from staging to active and sets status bit 1. The sync-group registers are left as they were.
- R7: An event pulse whose group has no pending store leaves the active registers unchanged.
- R8: A `noise_rdy_i` pulse sets status bit 2. A read of subaddress `33h` over I2C clears it after the byte is sent.
- R9: A subaddress that is neither mapped, `33h` nor `FFh` reads as `8'h00`, ignores writes, and still acknowledges data bytes.
- R10: The auto-incremented pointer wraps from `FFh` to `00h`, for both writes and reads.
- R11: Transfers work with the standard (100 kHz) and fast (400 kHz) bit timing.
- R12: After reset, all active registers are `8'h00`, the status byte reads `8'h03` and SDA is released.
- R13: Staged values written between a store and its commit event replace earlier staged values, and the commit copies the latest ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the pad |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| vsync_i | input | 1 | Vertical-sync pulse, one clock wide, commits the sync group |
| ostart_i | input | 1 | Output-cycle start pulse, one clock wide, commits the output group |
| noise_rdy_i | input | 1 | One-clock pulse marking a new noise measurement |
| act_o | output | NUM_REGS*8 | Active register bank, register k in bits [8k+7:8k] |

## Verification
The bench builds the block with its defaults. Eight registers are split by `OS_MASK = 8'hF0` into a sync group (0 to 3) and an output group (4 to 7), and a three-cycle glitch filter is used. With that split, a single store can be shown committing one half on `vsync_i` while the other half waits for `ostart_i`. The small map leaves wide unmapped gaps below `33h` and below `FFh`, and a write burst starting at `FEh` crosses the store address and wraps into register 0 in one transfer. With a 25 MHz system clock, quarter-bit phases of 16 and 62 cycles reproduce the fast and standard bus rates.

// File: rtl/i2c_cmt_pkg.sv
// Shared constants and types for the staged-commit I2C register bank.
// Assumes an 8-bit subaddress space and 8-bit registers.
package i2c_cmt_pkg;
    localparam logic [6:0] DEV_ADDR   = 7'h5E;
    localparam logic [7:0] SUB_STATUS = 8'h33;
    localparam logic [7:0] SUB_STORE  = 8'hFF;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_SUB,
        S_SACK,
        S_WDATA,
        S_WACK,
        S_RDATA,
        S_RACK
    } slv_state_e;
endpackage

// File: rtl/i2c_cmt_deglitch.sv
// Two-flop synchronizer followed by a stability filter for one bus line.
// The output follows the input only after it has held a new level for
// FILT_LEN consecutive clocks. Assumes an idle-high line (reset value 1).
module i2c_cmt_deglitch #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Synchronize the raw line and accept a new level only once it has been stable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            cnt_q   <= '0;
            clean_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == clean_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                clean_o <= sync_q[1];
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_cmt_slave.sv
// Bit-level I2C slave engine. It detects start and stop, matches the device
// address, shifts bytes in and out, and keeps the auto-incrementing 8-bit
// subaddress pointer. It hands the register side single-cycle write strobes
// and read loads. Assumes filtered, synchronous SCL/SDA and no clock stretching.
module i2c_cmt_slave
    import i2c_cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       rd_ld_o,
    output logic [7:0] rd_addr_o,
    input  logic [7:0] rd_data_i
);
    slv_state_e state_q;
    logic       scl_q, sda_q;
    logic [3:0] bitcnt_q;
    logic [7:0] shreg_q, txsh_q, ptr_q;
    logic       rw_q, mnack_q;
    logic       scl_rise, scl_fall, start_det, stop_det;

    // Edge and bus-condition detection on the filtered lines
    always_comb begin
        scl_rise  = scl_i & ~scl_q;
        scl_fall  = ~scl_i & scl_q;
        start_det = scl_i & scl_q & sda_q & ~sda_i;
        stop_det  = scl_i & scl_q & ~sda_q & sda_i;
    end

    // Register-side strobes: writes on byte completion, read loads when a byte is fetched
    always_comb begin
        wr_en_o   = scl_fall && !start_det && !stop_det && (state_q == S_WDATA) && (bitcnt_q == 4'd8);
        wr_addr_o = ptr_q;
        wr_data_o = shreg_q;
        rd_addr_o = (state_q == S_RACK) ? ptr_q + 8'd1 : ptr_q;
        rd_ld_o   = scl_fall && !start_det && !stop_det &&
                    (((state_q == S_AACK) && rw_q) || ((state_q == S_RACK) && !mnack_q));
    end

    // Protocol state machine, pointer and shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            txsh_q   <= '0;
            ptr_q    <= '0;
            rw_q     <= 1'b0;
            mnack_q  <= 1'b1;
            sda_oe_o <= 1'b0;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
            if (stop_det) begin
                state_q  <= S_IDLE;
                sda_oe_o <= 1'b0;
            end else if (start_det) begin
                state_q  <= S_ADDR;
                bitcnt_q <= '0;
                sda_oe_o <= 1'b0;
            end else if (scl_rise) begin
                case (state_q)
                    S_ADDR, S_SUB, S_WDATA: begin
                        shreg_q  <= {shreg_q[6:0], sda_i};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end
                    S_RDATA: bitcnt_q <= bitcnt_q + 4'd1;
                    S_RACK:  mnack_q  <= sda_i;
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (state_q)
                    S_ADDR: begin
                        if (bitcnt_q == 4'd8) begin
                            if (shreg_q[7:1] == DEV_ADDR) begin
                                sda_oe_o <= 1'b1;
                                rw_q     <= shreg_q[0];
                                state_q  <= S_AACK;
                            end else begin
                                state_q <= S_IDLE;
                            end
                        end
                    end
                    S_SUB: begin
                        if (bitcnt_q == 4'd8) begin
                            ptr_q    <= shreg_q;
                            sda_oe_o <= 1'b1;
                            state_q  <= S_SACK;
                        end
                    end
                    S_WDATA: begin
                        if (bitcnt_q == 4'd8) begin
                            sda_oe_o <= 1'b1;
                            state_q  <= S_WACK;
                        end
                    end
                    S_AACK: begin
                        bitcnt_q <= '0;
                        if (rw_q) begin
                            txsh_q   <= rd_data_i;
                            sda_oe_o <= ~rd_data_i[7];
                            state_q  <= S_RDATA;
                        end else begin
                            sda_oe_o <= 1'b0;
                            state_q  <= S_SUB;
                        end
                    end
                    S_SACK: begin
                        sda_oe_o <= 1'b0;
                        bitcnt_q <= '0;
                        state_q  <= S_WDATA;
                    end
                    S_WACK: begin
                        sda_oe_o <= 1'b0;
                        bitcnt_q <= '0;
                        ptr_q    <= ptr_q + 8'd1;
                        state_q  <= S_WDATA;
                    end
                    S_RDATA: begin
                        if (bitcnt_q == 4'd8) begin
                            sda_oe_o <= 1'b0;
                            state_q  <= S_RACK;
                        end else begin
                            txsh_q   <= {txsh_q[6:0], 1'b1};
                            sda_oe_o <= ~txsh_q[6];
                        end
                    end
                    S_RACK: begin
                        if (!mnack_q) begin
                            ptr_q    <= ptr_q + 8'd1;
                            txsh_q   <= rd_data_i;
                            sda_oe_o <= ~rd_data_i[7];
                            bitcnt_q <= '0;
                            state_q  <= S_RDATA;
                        end else begin
                            state_q <= S_IDLE;
                        end
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_cmt_bank.sv
// Staging and active register copies with group-timed commit and status.
// A write to SUB_STORE arms both groups. Each group copies staging to active
// on its own event pulse, then reports done. Assumes 2 <= NUM_REGS <= 51 so
// the map stays below the status subaddress, and one-clock event pulses.
module i2c_cmt_bank
    import i2c_cmt_pkg::*;
#(
    parameter int                    NUM_REGS = 8,
    parameter logic [NUM_REGS-1:0]   OS_MASK  = 'hF0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [7:0]               wr_addr_i,
    input  logic [7:0]               wr_data_i,
    input  logic                     rd_ld_i,
    input  logic [7:0]               rd_addr_i,
    output logic [7:0]               rd_data_o,
    input  logic                     vsync_i,
    input  logic                     ostart_i,
    input  logic                     noise_rdy_i,
    output logic [2:0]               status_o,
    output logic [NUM_REGS*8-1:0]    act_o
);
    localparam int         IDXW = $clog2(NUM_REGS);
    localparam logic [8:0] NREG = 9'(NUM_REGS);

    logic [7:0] stage_q [NUM_REGS];
    logic       vin_done_q, os_done_q, noise_q;
    logic       store;

    // Store command decode
    always_comb store = wr_en_i && (wr_addr_i == SUB_STORE);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam bit IS_OS = OS_MASK[i];
        logic [7:0] act_q;
        logic       commit;

        // Commit when this register's group event arrives with a store pending
        always_comb commit = IS_OS ? (ostart_i && !os_done_q) : (vsync_i && !vin_done_q);

        // Staging copy takes writes addressed to it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[i] <= '0;
            end else if (wr_en_i && (wr_addr_i == 8'(i))) begin
                stage_q[i] <= wr_data_i;
            end
        end

        // Active copy loads from staging on commit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q <= '0;
            end else if (commit) begin
                act_q <= stage_q[i];
            end
        end

        assign act_o[i*8 +: 8] = act_q;
    end

    // Per-group done flags: cleared by store, set by the group's event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vin_done_q <= 1'b1;
            os_done_q  <= 1'b1;
        end else if (store) begin
            vin_done_q <= 1'b0;
            os_done_q  <= 1'b0;
        end else begin
            if (vsync_i)  vin_done_q <= 1'b1;
            if (ostart_i) os_done_q  <= 1'b1;
        end
    end

    // Noise flag: set by a new measurement, cleared once the status byte is fetched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            noise_q <= 1'b0;
        end else if (noise_rdy_i) begin
            noise_q <= 1'b1;
        end else if (rd_ld_i && (rd_addr_i == SUB_STATUS)) begin
            noise_q <= 1'b0;
        end
    end

    assign status_o = {noise_q, os_done_q, vin_done_q};

    // Read mux: status, mapped staging register, or zero
    always_comb begin
        if (rd_addr_i == SUB_STATUS) begin
            rd_data_o = {5'b0, status_o};
        end else if ({1'b0, rd_addr_i} < NREG) begin
            rd_data_o = stage_q[rd_addr_i[IDXW-1:0]];
        end else begin
            rd_data_o = 8'h00;
        end
    end
endmodule

// File: rtl/i2c_cmt_regbank.sv
// Top level: I2C slave register bank whose writes are staged and become
// active only after a store command and the owning group's timing event.
// Assumes SCL/SDA pads are resolved outside; sda_oe_o=1 pulls SDA low.
module i2c_cmt_regbank #(
    parameter int                  NUM_REGS = 8,
    parameter logic [NUM_REGS-1:0] OS_MASK  = 'hF0,
    parameter int                  FILT_LEN = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic                  vsync_i,
    input  logic                  ostart_i,
    input  logic                  noise_rdy_i,
    output logic [NUM_REGS*8-1:0] act_o
);
    logic       scl_f, sda_f;
    logic       wr_en_w, rd_ld_w;
    logic [7:0] wr_addr_w, wr_data_w, rd_addr_w, rd_data_w;
    logic [2:0] status_w;

    i2c_cmt_deglitch #(.FILT_LEN(FILT_LEN)) u_scl_flt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .clean_o(scl_f)
    );

    i2c_cmt_deglitch #(.FILT_LEN(FILT_LEN)) u_sda_flt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .clean_o(sda_f)
    );

    i2c_cmt_slave u_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_f),
        .sda_i     (sda_f),
        .sda_oe_o  (sda_oe_o),
        .wr_en_o   (wr_en_w),
        .wr_addr_o (wr_addr_w),
        .wr_data_o (wr_data_w),
        .rd_ld_o   (rd_ld_w),
        .rd_addr_o (rd_addr_w),
        .rd_data_i (rd_data_w)
    );

    i2c_cmt_bank #(.NUM_REGS(NUM_REGS), .OS_MASK(OS_MASK)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_w),
        .wr_addr_i   (wr_addr_w),
        .wr_data_i   (wr_data_w),
        .rd_ld_i     (rd_ld_w),
        .rd_addr_i   (rd_addr_w),
        .rd_data_o   (rd_data_w),
        .vsync_i     (vsync_i),
        .ostart_i    (ostart_i),
        .noise_rdy_i (noise_rdy_i),
        .status_o    (status_w),
        .act_o       (act_o)
    );
endmodule

// File: rtl/i2c_cmt_regbank_chk.sv
// Property checker for the staged-commit register bank, bound to the top.
// It watches the write strobes from the slave engine, the status flags and
// the active outputs held by the bank.
module i2c_cmt_regbank_chk #(
    parameter int NUM_REGS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  vsync_i,
    input logic                  ostart_i,
    input logic                  noise_rdy_i,
    input logic                  wr_en,
    input logic [7:0]            wr_addr,
    input logic [2:0]            status,
    input logic [NUM_REGS*8-1:0] act_o
);
    logic store;
    assign store = wr_en && (wr_addr == 8'hFF);

    a_r3_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsync_i && !ostart_i) |=> $stable(act_o));

    a_r4_store_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> (status[1:0] == 2'b00));

    a_r5_vsync_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[0] && vsync_i && !store) |=> status[0]);

    a_r6_ostart_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[1] && ostart_i && !store) |=> status[1]);

    a_r7_no_commit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && status[1]) |=> $stable(act_o));

    a_r8_noise_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        noise_rdy_i |=> status[2]);
endmodule

bind i2c_cmt_regbank i2c_cmt_regbank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsync_i     (vsync_i),
    .ostart_i    (ostart_i),
    .noise_rdy_i (noise_rdy_i),
    .wr_en       (wr_en_w),
    .wr_addr     (wr_addr_w),
    .status      (status_w),
    .act_o       (act_o)
);

// File: tb/i2c_cmt_regbank_test.sv
// Self-checking bench: a bus master model drives SCL/SDA, a vector table
// covers write/readback, and directed tests cover commit, status and wrap.
module i2c_cmt_regbank_test;
    localparam int CLK_NS   = 40;
    localparam int NREGS    = 8;
    localparam int Q_FAST   = 16;
    localparam int Q_STD    = 62;
    localparam int WATCHDOG = 190000;
    // {subaddress, data written, expected readback}
    localparam logic [23:0] VEC [8] = '{
        24'h00_11_11, 24'h01_22_22, 24'h05_A5_A5, 24'h07_5A_5A,
        24'h10_77_00, 24'h40_33_00, 24'h03_FF_FF, 24'h06_0C_0C
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_lo = 1'b0;
    logic vsync = 1'b0, ostart = 1'b0, noise = 1'b0;
    logic sda_oe;
    logic sda;
    logic [NREGS*8-1:0] act;
    int checks = 0, errors = 0, q = Q_FAST;
    bit finished = 0;
    logic [7:0] wbuf [10];
    logic [7:0] rbuf [10];

    assign sda = ~(m_sda_lo | sda_oe);

    always #(CLK_NS/2) clk = ~clk;

    i2c_cmt_regbank uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda), .sda_oe_o(sda_oe),
        .vsync_i(vsync), .ostart_i(ostart), .noise_rdy_i(noise), .act_o(act)
    );

    function automatic logic [7:0] actb(int i);
        return act[i*8 +: 8];
    endfunction

    task automatic check(string req, logic [31:0] actual, logic [31:0] expct);
        checks++;
        if (actual !== expct) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, actual, expct);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda_lo = 0; tick(q); m_scl = 1; tick(q);
        m_sda_lo = 1; tick(q); m_scl = 0; tick(q);
    endtask

    task automatic bus_stop;
        m_sda_lo = 1; tick(q); m_scl = 1; tick(q);
        m_sda_lo = 0; tick(2*q);
    endtask

    task automatic wbyte(logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_lo = !b[i]; tick(q); m_scl = 1; tick(2*q); m_scl = 0; tick(q);
        end
        m_sda_lo = 0; tick(q); m_scl = 1; tick(q);
        ack = !sda;
        tick(q); m_scl = 0; tick(q);
    endtask

    task automatic rbyte(logic nack, output logic [7:0] b);
        m_sda_lo = 0;
        for (int i = 7; i >= 0; i--) begin
            tick(q); m_scl = 1; tick(q); b[i] = sda; tick(q); m_scl = 0; tick(q);
        end
        m_sda_lo = !nack; tick(q); m_scl = 1; tick(2*q); m_scl = 0; tick(q);
        m_sda_lo = 0;
    endtask

    // Write cnt bytes from wbuf; acks bit k = ACK seen on byte k (address first)
    task automatic write_seq(logic [7:0] dev, logic [7:0] sub, int cnt, output logic [9:0] acks);
        logic a;
        acks = '0;
        bus_start;
        wbyte(dev, a); acks[0] = a;
        wbyte(sub, a); acks[1] = a;
        for (int k = 0; k < cnt; k++) begin
            wbyte(wbuf[k], a); acks[k+2] = a;
        end
        bus_stop;
    endtask

    // Read cnt bytes into rbuf starting at sub; returns acks of the three address bytes
    task automatic read_seq(logic [7:0] sub, int cnt, output logic [2:0] acks);
        logic a;
        bus_start;
        wbyte(8'hBC, a); acks[0] = a;
        wbyte(sub, a);   acks[1] = a;
        bus_start;
        wbyte(8'hBD, a); acks[2] = a;
        for (int k = 0; k < cnt; k++) rbyte(k == cnt - 1, rbuf[k]);
        bus_stop;
    endtask

    task automatic pulse(int which);
        @(negedge clk);
        if (which == 0) vsync = 1; else if (which == 1) ostart = 1; else noise = 1;
        @(negedge clk);
        vsync = 0; ostart = 0; noise = 0;
        tick(2);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            summary;
        end
    end

    initial begin
        logic [9:0] wa;
        logic [2:0] ra;
        tick(5);
        rst_n = 1;
        tick(5);

        // R12: reset state
        check("R12 act", act, '0);
        check("R12 sda_oe", sda_oe, 0);
        read_seq(8'h33, 1, ra);
        check("R12 status", rbuf[0], 8'h03);

        // R2 R9: table of write/readback vectors
        foreach (VEC[v]) begin
            wbuf[0] = VEC[v][15:8];
            write_seq(8'hBC, VEC[v][23:16], 1, wa);
            check("R9 write ack", wa[2:0], 3'b111);
            read_seq(VEC[v][23:16], 1, ra);
            check("R2 readback", rbuf[0], VEC[v][7:0]);
        end
        check("R3 act untouched", act, '0);

        // R2: burst write and burst read with auto-increment
        for (int k = 0; k < 8; k++) wbuf[k] = 8'h10 + 8'(k);
        write_seq(8'hBC, 8'h00, 8, wa);
        check("R2 burst acks", wa, 10'h3FF);
        read_seq(8'h02, 3, ra);
        check("R2 burst read", {rbuf[0], rbuf[1], rbuf[2]}, 24'h121314);

        // R4: store clears both done bits, active still idle
        wbuf[0] = 8'h5C;
        write_seq(8'hBC, 8'hFF, 1, wa);
        read_seq(8'h33, 1, ra);
        check("R4 status after store", rbuf[0], 8'h00);
        check("R3 act before event", act, '0);

        // R6: output-start commits only the output group
        pulse(1);
        check("R6 act4", actb(4), 8'h14);
        check("R6 act7", actb(7), 8'h17);
        check("R6 act0 held", actb(0), 8'h00);
        read_seq(8'h33, 1, ra);
        check("R6 status", rbuf[0], 8'h02);

        // R13 R5: overwrite while pending, then vsync commits latest
        wbuf[0] = 8'hEE;
        write_seq(8'hBC, 8'h00, 1, wa);
        pulse(0);
        check("R13 act0 latest", actb(0), 8'hEE);
        check("R5 act3", actb(3), 8'h13);
        read_seq(8'h33, 1, ra);
        check("R5 status", rbuf[0], 8'h03);

        // R7: events with nothing pending have no effect
        wbuf[0] = 8'h99;
        write_seq(8'hBC, 8'h01, 1, wa);
        pulse(0);
        pulse(1);
        check("R7 act1 held", actb(1), 8'h11);
        check("R7 act5 held", actb(5), 8'h15);

        // R8: noise flag set by pulse, cleared by reading it
        pulse(2);
        read_seq(8'h33, 1, ra);
        check("R8 noise set", rbuf[0], 8'h07);
        read_seq(8'h33, 1, ra);
        check("R8 noise cleared", rbuf[0], 8'h03);

        // R1: foreign address is not acked and its bytes do nothing
        wbuf[0] = 8'h55;
        write_seq(8'hA0, 8'h01, 1, wa);
        check("R1 no ack", wa[0], 0);
        read_seq(8'h01, 1, ra);
        check("R1 own addr acks", ra, 3'b111);
        check("R1 no effect", rbuf[0], 8'h99);

        // R10: write burst from FEh wraps through store into register 0
        wbuf[0] = 8'h44; wbuf[1] = 8'h00; wbuf[2] = 8'h3C;
        write_seq(8'hBC, 8'hFE, 3, wa);
        check("R10 wrap acks", wa[4:0], 5'h1F);
        read_seq(8'h00, 1, ra);
        check("R10 wrap write", rbuf[0], 8'h3C);
        read_seq(8'h33, 1, ra);
        check("R10 store via wrap", rbuf[0], 8'h00);
        read_seq(8'hFF, 2, ra);
        check("R10 read wrap", {rbuf[0], rbuf[1]}, 16'h003C);
        pulse(0);
        check("R5 act0 after wrap", actb(0), 8'h3C);
        check("R5 act1 after wrap", actb(1), 8'h99);

        // R11: standard-rate timing
        q = Q_STD;
        wbuf[0] = 8'h6B;
        write_seq(8'hBC, 8'h02, 1, wa);
        check("R11 std acks", wa[2:0], 3'b111);
        read_seq(8'h02, 1, ra);
        check("R11 std readback", rbuf[0], 8'h6B);

        finished = 1;
        summary;
    end
endmodule